// File: doc/BRIEF.md
# Security-Aware GPIO Register Access Filter

This block is the register front end of a general-purpose I/O port. Every bus access carries a secure/non-secure attribute. The block uses that attribute to decide, bit by bit, what the access may read and write. A static mode input picks one of two policies:
- **Locked mode:** only secure masters may touch the port.
- **Shared mode:** individual pins can be opened to non-secure masters through a per-pin enable register. Only secure masters can write that register.

The port holds its control, event-control, direction, output, per-pin configuration, per-pin multiplexer, input-sampling and interrupt state behind one word-addressed slave interface. Direction and output also have clear, set and toggle aliases. A wide configuration write updates the configuration or multiplexer fields of many pins at once.

Non-secure code cannot write the per-pin enable register. To let it notice changes, a change-check mask selects enable bits to watch. When a secure write changes a watched bit, a single flag rises, and it can raise an interrupt.

An external write-protect input discards any write that survives the security filter.

Top module: `gpio_sec_port`

## Requirements
- R1: A secure access (req_nonsec=0) to any mapped register completes with full read and write effect and rsp_err=0, in both modes.
- R2: In locked mode (mode_mixed=0), a non-secure read returns rsp_rdata=0 with rsp_err=1.
- R3: In locked mode, a non-secure write changes no register and returns rsp_err=1.
- R4: In shared mode (mode_mixed=1), the change-check mask (0x03), interrupt-enable clear (0x04, bit 0), interrupt-enable set (0x05, bit 0) and flag (0x06, bit 0) registers are fully readable and writable by non-secure masters.
- R5: In shared mode, non-secure accesses to control (0x00) and event control (0x01) read as 0, write nothing, and return rsp_err=0.
- R6: In shared mode, non-secure masters can read the per-pin enable register (0x02), and their writes to it are dropped with rsp_err=0.
- R7: In shared mode, a non-secure access to the following registers reads and writes only bits n whose per-pin enable bit n is 1; other bits read 0 and are kept:
  - direction (0x08) and its clear/set/toggle aliases (0x09/0x0A/0x0B);
  - output (0x0C) and its aliases (0x0D/0x0E/0x0F);
  - input (0x10, read-only, reflects pins_in).
- R8: Per-pin config (0x20+n, bits [CFG_W-1:0]) and mux (0x40+n, bits [MUX_W-1:0]) are reachable by a non-secure master in shared mode only when enable bit n is 1. The wide write (0x11, reads 0) updates the pins selected in bits [NPINS-1:0]:
  - config is set from bits [23:16] when bit 30 is 1;
  - mux is set from bits [29:24] when bit 31 is 1;
  - for non-secure masters, the select is ANDed with the enable register.
- R9: The flag sets when a write changes a bit of the enable register whose change-check bit is 1. Writing 1 to flag bit 0 clears it. irq_o is flag AND enable.
- R10: While wr_lock=1 every write is discarded; rsp_err still follows R2–R3.
- R11: Each request (reads and writes alike) gets rsp_valid exactly one cycle later, with read data and rsp_err in that same cycle. rsp_err is never high without rsp_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_mixed | input | 1 | 0 locked mode, 1 shared mode (static) |
| wr_lock | input | 1 | External write protect |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 write, 0 read |
| req_nonsec | input | 1 | Access attribute, 1 non-secure |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| pins_in | input | NPINS | Sampled pad levels |
| rsp_valid | output | 1 | Response strobe |
| rsp_rdata | output | DATA_W | Read data |
| rsp_err | output | 1 | Bus error pulse |
| dir_o | output | NPINS | Direction per pin |
| out_o | output | NPINS | Output level per pin |
| pcfg_o | output | NPINS*CFG_W | Per-pin configuration |
| pmux_o | output | NPINS*MUX_W | Per-pin multiplexer select |
| ctrl_o | output | DATA_W | Control register |
| evctl_o | output | DATA_W | Event-control register |
| irq_o | output | 1 | Change-check interrupt |

## Verification
The bench targets the per-bit mask on the set/clear/toggle aliases. A filter that masked only the base register would let non-secure code toggle secure pins through the alias. It also targets the wide write's select mask: if that mask were not narrowed, a non-secure master could reconfigure secure pins. Further cases are a secure write to a watched enable bit and a write to an unwatched bit. A flag with the wrong change test would raise the interrupt on either every write or none. Write protect combined with a locked-mode non-secure write must still return the error while discarding the data. Mixing those up would either hide the error or let the write through.

// File: rtl/gpio_sec_pkg.sv
package gpio_sec_pkg;

    localparam int OFS_CTRL   = 'h00;
    localparam int OFS_EVCTL  = 'h01;
    localparam int OFS_NSEN   = 'h02;
    localparam int OFS_CHK    = 'h03;
    localparam int OFS_IENCLR = 'h04;
    localparam int OFS_IENSET = 'h05;
    localparam int OFS_IFLAG  = 'h06;
    localparam int OFS_DIR    = 'h08;
    localparam int OFS_DIRCLR = 'h09;
    localparam int OFS_DIRSET = 'h0A;
    localparam int OFS_DIRTGL = 'h0B;
    localparam int OFS_OUT    = 'h0C;
    localparam int OFS_OUTCLR = 'h0D;
    localparam int OFS_OUTSET = 'h0E;
    localparam int OFS_OUTTGL = 'h0F;
    localparam int OFS_IN     = 'h10;
    localparam int OFS_WCFG   = 'h11;
    localparam int PCFG_BASE  = 'h20;
    localparam int PMUX_BASE  = 'h40;

    // wide-config field positions
    localparam int WCFG_CFG_LSB = 16;
    localparam int WCFG_MUX_LSB = 24;
    localparam int WCFG_CFG_EN  = 30;
    localparam int WCFG_MUX_EN  = 31;

    typedef enum logic [2:0] {
        CLS_NONE,   // unmapped
        CLS_OPEN,   // open to both worlds
        CLS_SEC,    // secure only, silent for non-secure in shared mode
        CLS_WSEC,   // readable by all, writable by secure only
        CLS_MBIT,   // per-bit filtered by the pin enable vector
        CLS_MPIN    // whole register filtered by one pin enable bit
    } acc_cls_e;

    typedef enum logic [4:0] {
        RG_NONE, RG_CTRL, RG_EVCTL, RG_NSEN, RG_CHK, RG_IENCLR, RG_IENSET,
        RG_IFLAG, RG_DIR, RG_DIRCLR, RG_DIRSET, RG_DIRTGL, RG_OUT, RG_OUTCLR,
        RG_OUTSET, RG_OUTTGL, RG_IN, RG_WCFG, RG_PCFG, RG_PMUX
    } reg_e;

    function automatic acc_cls_e cls_of(reg_e r);
        case (r)
            RG_CTRL, RG_EVCTL:                      return CLS_SEC;
            RG_NSEN:                                return CLS_WSEC;
            RG_CHK, RG_IENCLR, RG_IENSET, RG_IFLAG: return CLS_OPEN;
            RG_PCFG, RG_PMUX:                       return CLS_MPIN;
            RG_NONE:                                return CLS_NONE;
            default:                                return CLS_MBIT;
        endcase
    endfunction

endpackage

// File: rtl/gpio_sec_decode.sv
module gpio_sec_decode
    import gpio_sec_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int NPINS  = 16,
    parameter int PIDX_W = $clog2(NPINS)
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_e              rg,
    output acc_cls_e          cls,
    output logic [PIDX_W-1:0] pin
);

    always_comb begin
        rg  = RG_NONE;
        pin = '0;
        if (addr >= ADDR_W'(PCFG_BASE) && addr < ADDR_W'(PCFG_BASE + NPINS)) begin
            rg  = RG_PCFG;
            pin = PIDX_W'(addr - ADDR_W'(PCFG_BASE));
        end else if (addr >= ADDR_W'(PMUX_BASE) && addr < ADDR_W'(PMUX_BASE + NPINS)) begin
            rg  = RG_PMUX;
            pin = PIDX_W'(addr - ADDR_W'(PMUX_BASE));
        end else begin
            case (addr)
                ADDR_W'(OFS_CTRL):   rg = RG_CTRL;
                ADDR_W'(OFS_EVCTL):  rg = RG_EVCTL;
                ADDR_W'(OFS_NSEN):   rg = RG_NSEN;
                ADDR_W'(OFS_CHK):    rg = RG_CHK;
                ADDR_W'(OFS_IENCLR): rg = RG_IENCLR;
                ADDR_W'(OFS_IENSET): rg = RG_IENSET;
                ADDR_W'(OFS_IFLAG):  rg = RG_IFLAG;
                ADDR_W'(OFS_DIR):    rg = RG_DIR;
                ADDR_W'(OFS_DIRCLR): rg = RG_DIRCLR;
                ADDR_W'(OFS_DIRSET): rg = RG_DIRSET;
                ADDR_W'(OFS_DIRTGL): rg = RG_DIRTGL;
                ADDR_W'(OFS_OUT):    rg = RG_OUT;
                ADDR_W'(OFS_OUTCLR): rg = RG_OUTCLR;
                ADDR_W'(OFS_OUTSET): rg = RG_OUTSET;
                ADDR_W'(OFS_OUTTGL): rg = RG_OUTTGL;
                ADDR_W'(OFS_IN):     rg = RG_IN;
                ADDR_W'(OFS_WCFG):   rg = RG_WCFG;
                default:             rg = RG_NONE;
            endcase
        end
    end

    assign cls = cls_of(rg);

endmodule

// File: rtl/gpio_sec_filter.sv
module gpio_sec_filter
    import gpio_sec_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int NPINS  = 16,
    parameter int PIDX_W = $clog2(NPINS)
) (
    input  acc_cls_e          cls,
    input  logic [PIDX_W-1:0] pin,
    input  logic              nonsec,
    input  logic              mixed,
    input  logic              wr_lock,
    input  logic [NPINS-1:0]  nsen,
    output logic [DATA_W-1:0] rd_mask,
    output logic [DATA_W-1:0] wr_mask,
    output logic              err
);

    logic [DATA_W-1:0] pin_vec;
    logic [DATA_W-1:0] raw_wr;

    assign pin_vec = DATA_W'(nsen);

    always_comb begin
        err     = 1'b0;
        rd_mask = '1;
        raw_wr  = '1;
        if (nonsec) begin
            if (!mixed) begin
                err     = 1'b1;
                rd_mask = '0;
                raw_wr  = '0;
            end else begin
                case (cls)
                    CLS_SEC:  begin rd_mask = '0;      raw_wr = '0;      end
                    CLS_WSEC: begin rd_mask = '1;      raw_wr = '0;      end
                    CLS_MBIT: begin rd_mask = pin_vec; raw_wr = pin_vec; end
                    CLS_MPIN: begin
                        rd_mask = nsen[pin] ? '1 : '0;
                        raw_wr  = nsen[pin] ? '1 : '0;
                    end
                    default:  begin rd_mask = '1;      raw_wr = '1;      end
                endcase
            end
        end
        wr_mask = wr_lock ? '0 : raw_wr;
    end

endmodule

// File: rtl/gpio_sec_regs.sv
module gpio_sec_regs
    import gpio_sec_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int NPINS  = 16,
    parameter int CFG_W  = 4,
    parameter int MUX_W  = 4,
    parameter int PIDX_W = $clog2(NPINS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic                   req_write,
    input  reg_e                   rg,
    input  logic [PIDX_W-1:0]      pin,
    input  logic [DATA_W-1:0]      rd_mask,
    input  logic [DATA_W-1:0]      wr_mask,
    input  logic                   err,
    input  logic [DATA_W-1:0]      wdata,
    input  logic [NPINS-1:0]       pins_in,
    output logic [NPINS-1:0]       nsen,
    output logic                   rsp_valid,
    output logic [DATA_W-1:0]      rsp_rdata,
    output logic                   rsp_err,
    output logic [NPINS-1:0]       dir_o,
    output logic [NPINS-1:0]       out_o,
    output logic [NPINS*CFG_W-1:0] pcfg_o,
    output logic [NPINS*MUX_W-1:0] pmux_o,
    output logic [DATA_W-1:0]      ctrl_o,
    output logic [DATA_W-1:0]      evctl_o,
    output logic                   irq_o
);

    typedef struct packed {
        logic [DATA_W-1:0]            ctrl;
        logic [DATA_W-1:0]            ev;
        logic [NPINS-1:0]             nsen;
        logic [NPINS-1:0]             chk;
        logic [NPINS-1:0]             dir;
        logic [NPINS-1:0]             out;
        logic [NPINS-1:0][CFG_W-1:0]  pcfg;
        logic [NPINS-1:0][MUX_W-1:0]  pmux;
        logic                         ien;
        logic                         flag;
        logic                         rvld;
        logic                         rerr;
        logic [DATA_W-1:0]            rdata;
    } state_t;

    state_t st_d, st_q;

    logic [DATA_W-1:0] wm;
    logic [NPINS-1:0]  pm;
    logic [NPINS-1:0]  wn;
    logic [NPINS-1:0]  sel;
    logic [DATA_W-1:0] raw;

    always_comb begin
        st_d      = st_q;
        st_d.rvld = req_valid;
        st_d.rerr = req_valid & err;
        st_d.rdata = '0;
        wm  = (req_valid && req_write) ? wr_mask : '0;
        pm  = wm[NPINS-1:0];
        wn  = wdata[NPINS-1:0];
        sel = wn & pm;
        raw = '0;
        case (rg)
            RG_CTRL: begin
                raw       = st_q.ctrl;
                st_d.ctrl = (st_q.ctrl & ~wm) | (wdata & wm);
            end
            RG_EVCTL: begin
                raw     = st_q.ev;
                st_d.ev = (st_q.ev & ~wm) | (wdata & wm);
            end
            RG_NSEN: begin
                raw       = DATA_W'(st_q.nsen);
                st_d.nsen = (st_q.nsen & ~pm) | (wn & pm);
                if (|((st_q.nsen ^ st_d.nsen) & st_q.chk)) st_d.flag = 1'b1;
            end
            RG_CHK: begin
                raw      = DATA_W'(st_q.chk);
                st_d.chk = (st_q.chk & ~pm) | (wn & pm);
            end
            RG_IENCLR: begin
                raw = DATA_W'(st_q.ien);
                if (wdata[0] && wm[0]) st_d.ien = 1'b0;
            end
            RG_IENSET: begin
                raw = DATA_W'(st_q.ien);
                if (wdata[0] && wm[0]) st_d.ien = 1'b1;
            end
            RG_IFLAG: begin
                raw = DATA_W'(st_q.flag);
                if (wdata[0] && wm[0]) st_d.flag = 1'b0;
            end
            RG_DIR: begin
                raw      = DATA_W'(st_q.dir);
                st_d.dir = (st_q.dir & ~pm) | sel;
            end
            RG_DIRCLR: begin raw = DATA_W'(st_q.dir); st_d.dir = st_q.dir & ~sel; end
            RG_DIRSET: begin raw = DATA_W'(st_q.dir); st_d.dir = st_q.dir | sel;  end
            RG_DIRTGL: begin raw = DATA_W'(st_q.dir); st_d.dir = st_q.dir ^ sel;  end
            RG_OUT: begin
                raw      = DATA_W'(st_q.out);
                st_d.out = (st_q.out & ~pm) | sel;
            end
            RG_OUTCLR: begin raw = DATA_W'(st_q.out); st_d.out = st_q.out & ~sel; end
            RG_OUTSET: begin raw = DATA_W'(st_q.out); st_d.out = st_q.out | sel;  end
            RG_OUTTGL: begin raw = DATA_W'(st_q.out); st_d.out = st_q.out ^ sel;  end
            RG_IN: raw = DATA_W'(pins_in);
            RG_WCFG: begin
                for (int i = 0; i < NPINS; i++) begin
                    if (sel[i]) begin
                        if (wdata[WCFG_CFG_EN]) st_d.pcfg[i] = wdata[WCFG_CFG_LSB +: CFG_W];
                        if (wdata[WCFG_MUX_EN]) st_d.pmux[i] = wdata[WCFG_MUX_LSB +: MUX_W];
                    end
                end
            end
            RG_PCFG: begin
                raw = DATA_W'(st_q.pcfg[pin]);
                if (wm[0]) st_d.pcfg[pin] = wdata[CFG_W-1:0];
            end
            RG_PMUX: begin
                raw = DATA_W'(st_q.pmux[pin]);
                if (wm[0]) st_d.pmux[pin] = wdata[MUX_W-1:0];
            end
            default: raw = '0;
        endcase
        if (req_valid && !req_write) st_d.rdata = raw & rd_mask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign nsen      = st_q.nsen;
    assign rsp_valid = st_q.rvld;
    assign rsp_rdata = st_q.rdata;
    assign rsp_err   = st_q.rerr;
    assign dir_o     = st_q.dir;
    assign out_o     = st_q.out;
    assign pcfg_o    = st_q.pcfg;
    assign pmux_o    = st_q.pmux;
    assign ctrl_o    = st_q.ctrl;
    assign evctl_o   = st_q.ev;
    assign irq_o     = st_q.flag & st_q.ien;

endmodule

// File: rtl/gpio_sec_port.sv
module gpio_sec_port
    import gpio_sec_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 32,
    parameter int NPINS  = 16,
    parameter int CFG_W  = 4,
    parameter int MUX_W  = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   mode_mixed,
    input  logic                   wr_lock,
    input  logic                   req_valid,
    input  logic                   req_write,
    input  logic                   req_nonsec,
    input  logic [ADDR_W-1:0]      req_addr,
    input  logic [DATA_W-1:0]      req_wdata,
    input  logic [NPINS-1:0]       pins_in,
    output logic                   rsp_valid,
    output logic [DATA_W-1:0]      rsp_rdata,
    output logic                   rsp_err,
    output logic [NPINS-1:0]       dir_o,
    output logic [NPINS-1:0]       out_o,
    output logic [NPINS*CFG_W-1:0] pcfg_o,
    output logic [NPINS*MUX_W-1:0] pmux_o,
    output logic [DATA_W-1:0]      ctrl_o,
    output logic [DATA_W-1:0]      evctl_o,
    output logic                   irq_o
);

    localparam int PIDX_W = $clog2(NPINS);

    reg_e              rg;
    acc_cls_e          cls;
    logic [PIDX_W-1:0] pin;
    logic [NPINS-1:0]  nsen;
    logic [DATA_W-1:0] rd_mask;
    logic [DATA_W-1:0] wr_mask;
    logic              err;

    gpio_sec_decode #(.ADDR_W(ADDR_W), .NPINS(NPINS), .PIDX_W(PIDX_W)) u_dec (
        .addr (req_addr),
        .rg   (rg),
        .cls  (cls),
        .pin  (pin)
    );

    gpio_sec_filter #(.DATA_W(DATA_W), .NPINS(NPINS), .PIDX_W(PIDX_W)) u_flt (
        .cls     (cls),
        .pin     (pin),
        .nonsec  (req_nonsec),
        .mixed   (mode_mixed),
        .wr_lock (wr_lock),
        .nsen    (nsen),
        .rd_mask (rd_mask),
        .wr_mask (wr_mask),
        .err     (err)
    );

    gpio_sec_regs #(
        .DATA_W(DATA_W), .NPINS(NPINS), .CFG_W(CFG_W), .MUX_W(MUX_W), .PIDX_W(PIDX_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .rg        (rg),
        .pin       (pin),
        .rd_mask   (rd_mask),
        .wr_mask   (wr_mask),
        .err       (err),
        .wdata     (req_wdata),
        .pins_in   (pins_in),
        .nsen      (nsen),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .rsp_err   (rsp_err),
        .dir_o     (dir_o),
        .out_o     (out_o),
        .pcfg_o    (pcfg_o),
        .pmux_o    (pmux_o),
        .ctrl_o    (ctrl_o),
        .evctl_o   (evctl_o),
        .irq_o     (irq_o)
    );

endmodule

// File: rtl/gpio_sec_chk.sv
module gpio_sec_chk #(
    parameter int DATA_W = 32,
    parameter int NPINS  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mode_mixed,
    input logic              wr_lock,
    input logic              req_valid,
    input logic              req_write,
    input logic              req_nonsec,
    input logic              rsp_valid,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic              rsp_err,
    input logic [NPINS-1:0]  dir_o,
    input logic [NPINS-1:0]  out_o,
    input logic [DATA_W-1:0] ctrl_o,
    input logic [DATA_W-1:0] evctl_o
);

    // R11
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R11
    err_needs_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> rsp_valid);

    // R1
    secure_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_nonsec |=> !rsp_err);

    // R2
    locked_ns_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_write && req_nonsec && !mode_mixed |=> rsp_err && rsp_rdata == '0);

    // R3
    locked_ns_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_write && req_nonsec && !mode_mixed |=>
            rsp_err && $stable(dir_o) && $stable(out_o) && $stable(ctrl_o) && $stable(evctl_o));

    // R5 (also covers the silent cases of R6, R7)
    shared_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && mode_mixed |=> !rsp_err);

    // R10
    wr_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_write && wr_lock |=>
            $stable(dir_o) && $stable(out_o) && $stable(ctrl_o) && $stable(evctl_o));

endmodule

bind gpio_sec_port gpio_sec_chk #(.DATA_W(DATA_W), .NPINS(NPINS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_mixed (mode_mixed),
    .wr_lock    (wr_lock),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_nonsec (req_nonsec),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata),
    .rsp_err    (rsp_err),
    .dir_o      (dir_o),
    .out_o      (out_o),
    .ctrl_o     (ctrl_o),
    .evctl_o    (evctl_o)
);

// File: tb/test_gpio_sec_port.sv
module test_gpio_sec_port;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        mode_mixed = 0, wr_lock = 0;
    logic        req_valid = 0, req_write = 0, req_nonsec = 0;
    logic [6:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [15:0] pins_in = '0;
    logic        rsp_valid, rsp_err, irq_o;
    logic [31:0] rsp_rdata, ctrl_o, evctl_o;
    logic [15:0] dir_o, out_o;
    logic [63:0] pcfg_o, pmux_o;

    int checks = 0, errors = 0, cycles = 0;

    logic [31:0] m_ctrl, m_ev;
    logic [15:0] m_nsen, m_chk, m_dir, m_out;
    logic [15:0][3:0] m_pcfg, m_pmux;
    logic m_ien, m_flag;

    gpio_sec_port i_gpio_sec_port (.*);

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog expired: act %0d exp < 150000 cycles", cycles);
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string rq, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: act %h exp %h", rq, what, act, exp);
        end
    endtask

    // class per the register map in the requirements: 0 none 1 open 2 sec 3 wsec 4 bit 5 pin
    function automatic int bcls(logic [6:0] a);
        if (a >= 7'h20 && a < 7'h30) return 5;
        if (a >= 7'h40 && a < 7'h50) return 5;
        case (a)
            7'h00, 7'h01: return 2;
            7'h02:        return 3;
            7'h03, 7'h04, 7'h05, 7'h06: return 1;
            7'h08, 7'h09, 7'h0A, 7'h0B, 7'h0C, 7'h0D, 7'h0E, 7'h0F, 7'h10, 7'h11: return 4;
            default:      return 0;
        endcase
    endfunction

    function automatic string tag(logic [6:0] a, bit ns, bit wr);
        int c = bcls(a);
        if (wr && wr_lock) return "R10";
        if (!ns) return "R1";
        if (!mode_mixed) return wr ? "R3" : "R2";
        case (c)
            1: return "R4";
            2: return "R5";
            3: return "R6";
            5: return "R8";
            default: return (a == 7'h11) ? "R8" : "R7";
        endcase
    endfunction

    task automatic acc(input bit wr, input bit ns, input logic [6:0] a, input logic [31:0] wd);
        logic [31:0] rm, wm, raw, exp_rd;
        logic [15:0] sel, old;
        bit e;
        int c = bcls(a);
        int p = a[3:0];
        string rq = tag(a, ns, wr);
        e = ns && !mode_mixed;
        rm = '1; wm = '1;
        if (ns) begin
            if (!mode_mixed) begin rm = 0; wm = 0; end
            else case (c)
                2: begin rm = 0; wm = 0; end
                3: begin rm = '1; wm = 0; end
                4: begin rm = {16'b0, m_nsen}; wm = rm; end
                5: begin rm = m_nsen[p] ? '1 : 0; wm = rm; end
                default: ;
            endcase
        end
        if (wr_lock || !wr) wm = 0;
        sel = wd[15:0] & wm[15:0];
        raw = 0;
        case (a)
            7'h00: begin raw = m_ctrl; m_ctrl = (m_ctrl & ~wm) | (wd & wm); end
            7'h01: begin raw = m_ev;   m_ev   = (m_ev & ~wm) | (wd & wm); end
            7'h02: begin
                raw = {16'b0, m_nsen}; old = m_nsen;
                m_nsen = (m_nsen & ~wm[15:0]) | sel;
                if (|((old ^ m_nsen) & m_chk)) m_flag = 1;
            end
            7'h03: begin raw = {16'b0, m_chk}; m_chk = (m_chk & ~wm[15:0]) | sel; end
            7'h04: begin raw = {31'b0, m_ien}; if (sel[0]) m_ien = 0; end
            7'h05: begin raw = {31'b0, m_ien}; if (sel[0]) m_ien = 1; end
            7'h06: begin raw = {31'b0, m_flag}; if (sel[0]) m_flag = 0; end
            7'h08: begin raw = {16'b0, m_dir}; m_dir = (m_dir & ~wm[15:0]) | sel; end
            7'h09: begin raw = {16'b0, m_dir}; m_dir &= ~sel; end
            7'h0A: begin raw = {16'b0, m_dir}; m_dir |= sel; end
            7'h0B: begin raw = {16'b0, m_dir}; m_dir ^= sel; end
            7'h0C: begin raw = {16'b0, m_out}; m_out = (m_out & ~wm[15:0]) | sel; end
            7'h0D: begin raw = {16'b0, m_out}; m_out &= ~sel; end
            7'h0E: begin raw = {16'b0, m_out}; m_out |= sel; end
            7'h0F: begin raw = {16'b0, m_out}; m_out ^= sel; end
            7'h10: raw = {16'b0, pins_in};
            7'h11: for (int i = 0; i < 16; i++) if (sel[i]) begin
                if (wd[30]) m_pcfg[i] = wd[19:16];
                if (wd[31]) m_pmux[i] = wd[27:24];
            end
            default: begin
                if (c == 5 && a < 7'h40) begin raw = {28'b0, m_pcfg[p]}; if (wm[0]) m_pcfg[p] = wd[3:0]; end
                else if (c == 5) begin raw = {28'b0, m_pmux[p]}; if (wm[0]) m_pmux[p] = wd[3:0]; end
            end
        endcase
        exp_rd = wr ? 0 : (raw & rm);
        req_valid = 1; req_write = wr; req_nonsec = ns; req_addr = a; req_wdata = wd;
        @(negedge clk);
        req_valid = 0;
        chk("R11", "rsp_valid", {63'b0, rsp_valid}, 64'd1);
        chk(rq, "rsp_err", {63'b0, rsp_err}, {63'b0, e});
        chk(rq, "rdata", {32'b0, rsp_rdata}, {32'b0, exp_rd});
        chk(rq, "dir", {48'b0, dir_o}, {48'b0, m_dir});
        chk(rq, "out", {48'b0, out_o}, {48'b0, m_out});
        chk(rq, "ctrl", {32'b0, ctrl_o}, {32'b0, m_ctrl});
        chk(rq, "evctl", {32'b0, evctl_o}, {32'b0, m_ev});
        chk(rq, "pcfg", pcfg_o, m_pcfg);
        chk(rq, "pmux", pmux_o, m_pmux);
        chk("R9", "irq", {63'b0, irq_o}, {63'b0, m_flag & m_ien});
    endtask

    function automatic logic [6:0] rnd_addr();
        int r = $urandom % 22;
        if (r < 17) return (r < 7) ? 7'(r) : 7'(r + 1);
        if (r == 17) return 7'h07;
        if (r < 20) return 7'h20 + 7'($urandom % 16);
        return 7'h40 + 7'($urandom % 16);
    endfunction

    initial begin
        void'($urandom(32'h5EC0_1234));
        m_ctrl = 0; m_ev = 0; m_nsen = 0; m_chk = 0; m_dir = 0; m_out = 0;
        m_pcfg = 0; m_pmux = 0; m_ien = 0; m_flag = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R11 reset state
        chk("R11", "idle rsp_valid", {63'b0, rsp_valid}, 0);
        chk("R9", "reset irq", {63'b0, irq_o}, 0);
        chk("R1", "reset dir", {48'b0, dir_o}, 0);

        // locked mode directed (R2, R3)
        mode_mixed = 0;
        acc(1, 0, 7'h08, 32'h0000_00F0);
        acc(1, 1, 7'h0B, 32'h0000_FFFF);
        chk("R3", "dir kept", {48'b0, dir_o}, 64'h00F0);
        acc(0, 1, 7'h08, 0);

        // shared mode directed
        mode_mixed = 1;
        acc(1, 0, 7'h02, 32'h0000_0F0F);
        acc(1, 1, 7'h0B, 32'h0000_FFFF);            // R7 toggle only open pins
        chk("R7", "alias mask", {48'b0, dir_o}, 64'h00F0 ^ 64'h0F0F);
        acc(1, 1, 7'h02, 32'h0000_FFFF);            // R6 dropped
        acc(1, 1, 7'h00, 32'hFFFF_FFFF);            // R5
        acc(1, 1, 7'h11, 32'hC300_FFFF | 32'h0005_0000); // R8 wide write
        acc(1, 0, 7'h03, 32'h0000_0008);
        acc(1, 1, 7'h05, 1);                        // R4 enable set
        acc(1, 0, 7'h02, 32'h0000_0F07);            // R9 watched bit 3 changes
        chk("R9", "irq raised", {63'b0, irq_o}, 1);
        acc(1, 1, 7'h06, 1);                        // R4 clear flag
        chk("R9", "irq cleared", {63'b0, irq_o}, 0);
        acc(1, 0, 7'h02, 32'h0000_0F17);            // unwatched bit 4
        chk("R9", "unwatched", {63'b0, irq_o}, 0);
        wr_lock = 1;
        acc(1, 0, 7'h08, 32'h0000_FFFF);            // R10
        mode_mixed = 0;
        acc(1, 1, 7'h08, 32'h0000_FFFF);            // R10 with R3 error
        wr_lock = 0;

        // random phases in both modes
        for (int ph = 0; ph < 4; ph++) begin
            mode_mixed = ph[0];
            for (int k = 0; k < 1500; k++) begin
                logic [6:0] a = rnd_addr();
                pins_in = 16'($urandom);
                wr_lock = (($urandom % 8) == 0);
                acc(1'($urandom % 2), 1'($urandom % 2), a, $urandom);
            end
        end
        wr_lock = 0;
        @(negedge clk);
        chk("R11", "idle again", {63'b0, rsp_valid}, 0);
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule